// File: doc/BRIEF.md
# UART Receive Queue with Idle-Age Detection

This block sits behind a UART deserializer and holds received characters until software or a DMA engine collects them. Each stored entry keeps the 8-bit character together with the frame-error and parity-error bits that belonged to that very character. Reading therefore returns the character and its own error status in one word.

Two conditions call for service. A level flag rises once the number of queued characters reaches a programmable threshold. A typical setting is 24 entries out of 32, which leaves 8 entries of slack before overrun. An age flag rises when characters are waiting below that level and the line has gone quiet for a set number of character periods. This lets a short trailing message be collected without waiting for the level. Each flag has its own enable into a combined interrupt.

All flags are sticky and are cleared by writing ones to their bits. A data-present output stays high while any entry remains, so a reader can drain the whole queue, not only the threshold count. Serial framing and baud timing are done elsewhere. The block sees one strobe per completed character and one tick per character period.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset the queue is empty: `dataPresent`, `readyFlag`, `agingFlag`, `overrunFlag` and `irq` are 0, and `rdData` is 0.
- R2: Characters leave in arrival order. `rdData` shows the oldest entry, with the character in bits 7:0, its frame-error bit in bit 8 and its parity-error bit in bit 9. A `rdStrobe` removes that entry.
- R3: `dataPresent` is high in the cycle after a character is accepted, and stays high until every stored entry has been read, even after the count has dropped below the threshold.
- R4: `readyFlag` becomes 1 one cycle after the stored count first becomes greater than or equal to `threshold`. It is sticky. While the count is still at or above the threshold, its set condition wins over a clear.
- R5: While the queue is non-empty, `agingFlag` becomes 1 after `AGE_CHARS` `charTick` pulses with no accepted character and no read in between. Any accepted character or read restarts the count. Ticks seen while the queue is empty are not counted.
- R6: `irq` is high exactly when (`readyFlag` and `readyEn`) or (`agingFlag` and `agingEn`). The overrun flag does not drive `irq`.
- R7: When `statusWr` is high, each 1 in `statusBits` clears one flag: bit 0 clears ready, bit 1 clears aging, bit 2 clears overrun. A 0 bit leaves its flag unchanged. Writing all ones clears every flag whose set condition is no longer present.
- R8: A character strobed in while the queue holds `DEPTH` entries, with no read in the same cycle, is dropped. It sets the sticky `overrunFlag`, and the stored entries stay unchanged.
- R9: A `rdStrobe` while the queue is empty has no effect. `rdData` reads 0 and the pointers do not move, so the next accepted character is the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | One-cycle strobe: a received character is offered |
| chData | input | 8 | Received character |
| chFrameErr | input | 1 | Frame error for this character |
| chParityErr | input | 1 | Parity error for this character |
| charTick | input | 1 | One pulse per character period |
| rdStrobe | input | 1 | Remove the oldest entry |
| threshold | input | $clog2(DEPTH)+1 | Fill level that raises the ready flag |
| readyEn | input | 1 | Lets the ready flag drive `irq` |
| agingEn | input | 1 | Lets the aging flag drive `irq` |
| statusWr | input | 1 | Write strobe for the clear bits |
| statusBits | input | 3 | Clear bits: {overrun, aging, ready} |
| rdData | output | 10 | {parityErr, frameErr, char} of the oldest entry, 0 when empty |
| dataPresent | output | 1 | At least one entry is stored |
| readyFlag | output | 1 | Sticky threshold-reached flag |
| agingFlag | output | 1 | Sticky idle-age flag |
| overrunFlag | output | 1 | Sticky dropped-character flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench builds the block with `DEPTH` = 8 and `AGE_CHARS` = 3, using a threshold of 5. This keeps filling to full, overrun, wrapping of the pointers and expiry of the idle interval within a few dozen cycles each. The same paths are used at the default depth of 32 and age of 8. The aging checks place ticks on both sides of the limit, and they also restart the interval with a mid-count character.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  parameter int CHAR_W = 8;

  typedef struct packed {
    logic parityErr;
    logic frameErr;
    logic [CHAR_W-1:0] ch;
  } rxEntry_t;

  typedef struct packed {
    logic pushEn;
    logic popEn;
  } rxqCtl_t;

  localparam int STAT_READY   = 0;
  localparam int STAT_AGING   = 1;
  localparam int STAT_OVERRUN = 2;
  localparam int STAT_W       = 3;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rxqCtl_t         ctl,
  input  rxEntry_t        wrEntry,
  output rxEntry_t        headEntry,
  output logic [CNT_W-1:0] count,
  output logic            full,
  output logic            empty
);
  rxEntry_t mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.pushEn) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.pushEn) wrPtr <= nextPtr(wrPtr);
      if (ctl.popEn)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.pushEn, ctl.popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.popEn |-> !empty);
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pushEn && !ctl.popEn) |=> count == $past(count) + 1'b1);
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pushEn && full) |-> ctl.popEn);
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AGE_CHARS = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int AGE_W = $clog2(AGE_CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chValid,
  input  logic              rdStrobe,
  input  logic              charTick,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              statusWr,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  input  logic              empty,
  output rxqCtl_t           ctl,
  output logic              readyFlag,
  output logic              agingFlag,
  output logic              overrunFlag
);
  logic [AGE_W-1:0] ageCount;
  logic pop, push, drop, ageHit;
  logic [STAT_W-1:0] clr;

  assign pop    = rdStrobe && !empty;
  assign push   = chValid && (!full || pop);
  assign drop   = chValid && full && !pop;
  assign ageHit = !empty && (ageCount == AGE_W'(AGE_CHARS));
  assign clr    = statusWr ? statusBits : '0;

  assign ctl.pushEn = push;
  assign ctl.popEn  = pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ageCount <= '0;
    end else if (push || pop || empty) begin
      ageCount <= '0;
    end else if (charTick && ageCount != AGE_W'(AGE_CHARS)) begin
      ageCount <= ageCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readyFlag   <= 1'b0;
      agingFlag   <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      readyFlag   <= (count >= threshold) || (readyFlag && !clr[STAT_READY]);
      agingFlag   <= ageHit || (agingFlag && !clr[STAT_AGING]);
      overrunFlag <= drop || (overrunFlag && !clr[STAT_OVERRUN]);
    end
  end

  a_r5_age_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(agingFlag) |-> $past(!empty));
  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (chValid && full && !rdStrobe) |=> overrunFlag);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWr && statusBits[STAT_OVERRUN] && !drop) |=> !overrunFlag);
  a_r5_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ageCount <= AGE_W'(AGE_CHARS));
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AGE_CHARS = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int ENTRY_W = CHAR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chValid,
  input  logic [CHAR_W-1:0]  chData,
  input  logic               chFrameErr,
  input  logic               chParityErr,
  input  logic               charTick,
  input  logic               rdStrobe,
  input  logic [CNT_W-1:0]   threshold,
  input  logic               readyEn,
  input  logic               agingEn,
  input  logic               statusWr,
  input  logic [STAT_W-1:0]  statusBits,
  output logic [ENTRY_W-1:0] rdData,
  output logic               dataPresent,
  output logic               readyFlag,
  output logic               agingFlag,
  output logic               overrunFlag,
  output logic               irq
);
  rxqCtl_t ctl;
  rxEntry_t wrEntry, headEntry;
  logic [CNT_W-1:0] count;
  logic full, empty;

  assign wrEntry = '{parityErr: chParityErr, frameErr: chFrameErr, ch: chData};

  uart_rxq_ctrl #(.DEPTH(DEPTH), .AGE_CHARS(AGE_CHARS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .rdStrobe(rdStrobe),
    .charTick(charTick), .threshold(threshold), .statusWr(statusWr),
    .statusBits(statusBits), .count(count), .full(full), .empty(empty),
    .ctl(ctl), .readyFlag(readyFlag), .agingFlag(agingFlag),
    .overrunFlag(overrunFlag)
  );

  uart_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrEntry(wrEntry),
    .headEntry(headEntry), .count(count), .full(full), .empty(empty)
  );

  assign rdData      = empty ? '0 : ENTRY_W'(headEntry);
  assign dataPresent = !empty;
  assign irq         = (readyFlag && readyEn) || (agingFlag && agingEn);

  a_r3_present_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pushEn |=> dataPresent);
endmodule

// File: tb/tb_uart_rxq_top.sv
module tb_uart_rxq_top;
  localparam int DEPTH = 8;
  localparam int AGE = 3;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic chValid = 0, chFrameErr = 0, chParityErr = 0, charTick = 0, rdStrobe = 0;
  logic [7:0] chData = 0;
  logic [CW-1:0] threshold = CW'(5);
  logic readyEn = 0, agingEn = 0, statusWr = 0;
  logic [2:0] statusBits = 0;
  logic [9:0] rdData;
  logic dataPresent, readyFlag, agingFlag, overrunFlag, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_rxq_top #(.DEPTH(DEPTH), .AGE_CHARS(AGE)) dut (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .chData(chData),
    .chFrameErr(chFrameErr), .chParityErr(chParityErr), .charTick(charTick),
    .rdStrobe(rdStrobe), .threshold(threshold), .readyEn(readyEn),
    .agingEn(agingEn), .statusWr(statusWr), .statusBits(statusBits),
    .rdData(rdData), .dataPresent(dataPresent), .readyFlag(readyFlag),
    .agingFlag(agingFlag), .overrunFlag(overrunFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic fe, input logic pe);
    chValid = 1; chData = d; chFrameErr = fe; chParityErr = pe;
    @(negedge clk);
    chValid = 0; chFrameErr = 0; chParityErr = 0;
  endtask

  task automatic pop();
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      charTick = 1; @(negedge clk); charTick = 0;
    end
  endtask

  task automatic clearStat(input logic [2:0] b);
    statusWr = 1; statusBits = b;
    @(negedge clk);
    statusWr = 0; statusBits = 0;
  endtask

  task automatic testReset();
    check("R1 present", dataPresent, 0);
    check("R1 flags", {readyFlag, agingFlag, overrunFlag}, 0);
    check("R1 irq", irq, 0);
    check("R1 rdData", rdData, 0);
  endtask

  task automatic testOrder();
    push(8'h41, 0, 0);
    push(8'h42, 1, 0);
    push(8'h43, 0, 1);
    check("R3 present", dataPresent, 1);
    check("R2 first", rdData, 10'h041); pop();
    check("R2 frame bit", rdData, 10'h142); pop();
    check("R2 parity bit", rdData, 10'h243); pop();
    check("R3 drained", dataPresent, 0);
  endtask

  task automatic testEmptyRead();
    pop();
    check("R9 rdData zero", rdData, 0);
    check("R9 still empty", dataPresent, 0);
    push(8'h5a, 0, 0);
    check("R9 next char", rdData, 10'h05a);
    pop();
    check("R9 empty again", dataPresent, 0);
  endtask

  task automatic testReady();
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i), 0, 0);
    idle(1);
    check("R4 below threshold", readyFlag, 0);
    push(8'h14, 0, 0);
    idle(1);
    check("R4 at threshold", readyFlag, 1);
    check("R6 ready masked", irq, 0);
    readyEn = 1; #1;
    check("R6 ready irq", irq, 1);
    clearStat(3'b001);
    idle(1);
    check("R4 set wins over clear", readyFlag, 1);
    for (int i = 0; i < 5; i++) begin
      check("R3 drain past threshold", rdData, 32'(8'h10 + 8'(i)));
      pop();
    end
    check("R3 empty after drain", dataPresent, 0);
    clearStat(3'b001);
    check("R7 ready cleared", readyFlag, 0);
    check("R6 irq low", irq, 0);
    readyEn = 0;
  endtask

  task automatic testAging();
    tick(5); idle(2);
    check("R5 empty ticks ignored", agingFlag, 0);
    push(8'h61, 0, 0);
    tick(2); idle(2);
    check("R5 before limit", agingFlag, 0);
    push(8'h62, 0, 0);
    tick(2); idle(2);
    check("R5 restart by char", agingFlag, 0);
    tick(1); idle(2);
    check("R5 expired", agingFlag, 1);
    check("R6 aging masked", irq, 0);
    agingEn = 1; #1;
    check("R6 aging irq", irq, 1);
    pop(); pop();
    clearStat(3'b010);
    check("R7 aging cleared", agingFlag, 0);
    agingEn = 0;
  endtask

  task automatic testOverrun();
    for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i), 0, 0);
    push(8'hee, 1, 1);
    check("R8 overrun set", overrunFlag, 1);
    clearStat(3'b011);
    check("R7 zero bit keeps overrun", overrunFlag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R8 contents kept", rdData, 32'(8'h80 + 8'(i)));
      pop();
    end
    check("R8 dropped char absent", dataPresent, 0);
    clearStat(3'b111);
    check("R7 all ones clears", {readyFlag, agingFlag, overrunFlag}, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testOrder();
    testEmptyRead();
    testReady();
    testAging();
    testOverrun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule